// File: doc/BRIEF.md
# Frame-synchronous register list loader

This block applies a list of configuration register writes once per frame. Software places a list of entries in memory. Each entry is one word naming a target register, followed by one 32-bit data word. Software then gives the block the list's location through a small register port: first the entry count, then the base pointer. When a frame-end pulse arrives, the block walks the list over a simple memory read port and emits one write on its register-write port for each entry. It then waits for the next frame-start pulse before it lets frame processing resume.

Only one new list can wait at a time. A pointer write that arrives before the next frame end replaces the list that was waiting. A pending bit shows whether a written list has not yet been taken up. When no new list is waiting, the list last taken up is fetched and applied again at every frame end. A shadow readback shows the programmed pointer while the fetcher is idle, and the base of the list being fetched while a fetch runs. The block keeps sticky flags for frame start, frame end and overrun. Writing 1 to a flag clears it. An enable mask gates the flags onto one interrupt line.

Top module: `frame_list_loader`

## Requirements
- R1: A write to select 0 (pointer) stores the pointer, together with the count held at select 1, as the waiting list, and sets status bit 0 (pending). Pending returns to 0 when a frame end is accepted. A frame end is accepted when it arrives while the fetcher is idle. If a pointer write lands in the same cycle as an accepted frame end, the fetch uses the list that was waiting before the write, and pending stays 1.
- R2: Entry i of a list with base B is read as the address word at B+8*i and then the data word at B+8*i+4. The reads go in entry order. Each read is a one-cycle mem_req pulse. The next read is issued only after mem_rvalid has returned the previous one.
- R3: Each entry produces exactly one reg_we pulse. It comes in the cycle in which the data word's mem_rvalid is high. reg_waddr carries the low RAW bits of the address word and reg_wdata carries the data word.
- R4: An accepted frame end with no waiting list fetches and applies again the list that was last taken up.
- R5: The queue for waiting lists is one deep. A second pointer write before the frame end replaces the first, and only the second list is fetched.
- R6: A list whose count is 0 produces no memory read and no register write.
- R7: Select 4 (shadow) reads the pointer last written while the fetcher is idle. While a fetch runs, it reads the base of the list being fetched, even if software writes a new pointer during that fetch.
- R8: A frame end that arrives while a fetch runs is ignored. The running fetch continues unchanged and no extra reads are issued. The frame end sets the sticky overrun flag, status bit 3.
- R9: A frame-start pulse sets status bit 1 and every frame-end pulse sets status bit 2. Both flags are sticky. Writing 1 to a status bit (1 to 3) at select 2 clears that bit.
- R10: irq is high one cycle after any status bit 1 to 3 is high together with the matching bit of the enable register at select 3. It is low one cycle after no such pair remains.
- R11: run goes low in the cycle after an accepted frame end. It goes high in the cycle after a frame-start pulse that arrives while the fetcher is idle. A frame start during a fetch leaves run low.
- R12: After reset, status, shadow, run, irq, mem_req and reg_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_sel | input | 3 | Write select: 0 pointer, 1 count, 2 status (write 1 to clear), 3 enable |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 3 | Read select: 0 to 3 as for writes, 4 shadow |
| cfg_rdata | output | 32 | Read data, combinational from cfg_rsel |
| frame_start | input | 1 | Frame-start pulse |
| frame_end | input | 1 | Frame-end pulse |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| reg_we | output | 1 | Configuration register write strobe |
| reg_waddr | output | RAW | Target register address |
| reg_wdata | output | 32 | Target register data |
| run | output | 1 | Frame processing may proceed |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A frame-end pulse sampled at one edge leaves mem_req high, pending low and the shadow showing the fetch base just after that edge. The bench therefore reads these values at the next falling edge. Reads and writes then follow the memory model's latency. A scoreboard of expected read addresses and (register, data) pairs is filled from the list parameters before each frame end, and every mem_req or reg_we seen at a falling edge is compared to it, so the exact order is checked and any surplus event counts as a failure. Flags change one edge after their pulse and irq one edge after that, so the bench waits two cycles before reading them. run is checked at the falling edge that follows the pulse that moves it.

// File: rtl/flp_pkg.sv
`timescale 1ns/1ps
package flp_pkg;
   typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_st_t;
   localparam logic [2:0] SEL_PTR    = 3'd0;
   localparam logic [2:0] SEL_CNT    = 3'd1;
   localparam logic [2:0] SEL_STAT   = 3'd2;
   localparam logic [2:0] SEL_IEN    = 3'd3;
   localparam logic [2:0] SEL_SHADOW = 3'd4;
   localparam int ST_PEND  = 0;
   localparam int ST_START = 1;
   localparam int ST_END   = 2;
   localparam int ST_OVR   = 3;
endpackage

// File: rtl/flp_fetch.sv
`timescale 1ns/1ps
module flp_fetch
   import flp_pkg::*;
#(
   parameter int AW  = 32,
   parameter int CW  = 8,
   parameter int RAW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [AW-1:0]  go_base,
   input  logic [CW-1:0]  go_count,
   output logic           busy,
   output logic [AW-1:0]  cur_base,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [31:0]    mem_rdata,
   output logic           reg_we,
   output logic [RAW-1:0] reg_waddr,
   output logic [31:0]    reg_wdata
);
   localparam int ENTRY_SHIFT = 3;
   localparam logic [AW-1:0] DATA_OFS = AW'(4);

   fetch_st_t      st;
   logic           phase;
   logic [CW-1:0]  idx;
   logic [CW-1:0]  lcnt;
   logic [AW-1:0]  lbase;
   logic [RAW-1:0] waddr_q;
   logic           last;

   assign last = (idx == lcnt - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         phase   <= 1'b0;
         idx     <= '0;
         lcnt    <= '0;
         lbase   <= '0;
         waddr_q <= '0;
      end else begin
         case (st)
            F_IDLE: begin
               if (go && go_count != '0) begin
                  st    <= F_REQ;
                  lbase <= go_base;
                  lcnt  <= go_count;
                  idx   <= '0;
                  phase <= 1'b0;
               end
            end
            F_REQ: st <= F_WAIT;
            F_WAIT: begin
               if (mem_rvalid) begin
                  if (!phase) begin
                     waddr_q <= mem_rdata[RAW-1:0];
                     phase   <= 1'b1;
                     st      <= F_REQ;
                  end else begin
                     phase <= 1'b0;
                     if (last) begin
                        st <= F_IDLE;
                     end else begin
                        idx <= idx + 1'b1;
                        st  <= F_REQ;
                     end
                  end
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   assign busy      = (st != F_IDLE);
   assign cur_base  = lbase;
   assign mem_req   = (st == F_REQ);
   assign mem_addr  = lbase + (AW'(idx) << ENTRY_SHIFT) + (phase ? DATA_OFS : '0);
   assign reg_we    = (st == F_WAIT) && phase && mem_rvalid;
   assign reg_waddr = waddr_q;
   assign reg_wdata = mem_rdata;

   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req) else $error("request longer than one cycle"); // R2
   AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(lbase))) else $error("base changed mid-fetch"); // R8
   AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we) else $error("back-to-back register writes"); // R3
endmodule

// File: rtl/flp_regs.sv
`timescale 1ns/1ps
module flp_regs
   import flp_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   input  logic          frame_start,
   input  logic          frame_end,
   input  logic          fetch_busy,
   output logic          go,
   output logic [AW-1:0] go_base,
   output logic [CW-1:0] go_count,
   output logic [AW-1:0] q_base,
   output logic [CW-1:0] cnt_val,
   output logic [3:0]    status,
   output logic [3:0]    ien,
   output logic          run,
   output logic          irq
);
   logic [AW-1:0] q_base_r, act_base_r;
   logic [CW-1:0] cnt_r, q_cnt_r, act_cnt_r;
   logic          pend_r, act_vld_r;
   logic          f_start, f_end, f_ovr;
   logic [3:1]    ien_r;
   logic          run_r;
   logic          ptr_we, stat_we, accept;
   logic          irq_raw;

   assign ptr_we  = cfg_we && (cfg_sel == SEL_PTR);
   assign stat_we = cfg_we && (cfg_sel == SEL_STAT);
   assign accept  = frame_end && !fetch_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_base_r   <= '0;
         q_cnt_r    <= '0;
         cnt_r      <= '0;
         pend_r     <= 1'b0;
         act_base_r <= '0;
         act_cnt_r  <= '0;
         act_vld_r  <= 1'b0;
         f_start    <= 1'b0;
         f_end      <= 1'b0;
         f_ovr      <= 1'b0;
         ien_r      <= '0;
         run_r      <= 1'b0;
      end else begin
         if (cfg_we && cfg_sel == SEL_CNT) cnt_r <= cfg_wdata[CW-1:0];
         if (cfg_we && cfg_sel == SEL_IEN) ien_r <= cfg_wdata[3:1];
         if (ptr_we) begin
            q_base_r <= cfg_wdata[AW-1:0];
            q_cnt_r  <= cnt_r;
         end
         if (ptr_we)      pend_r <= 1'b1;
         else if (accept) pend_r <= 1'b0;
         if (accept && pend_r) begin
            act_base_r <= q_base_r;
            act_cnt_r  <= q_cnt_r;
            act_vld_r  <= 1'b1;
         end
         if (frame_start)                         f_start <= 1'b1;
         else if (stat_we && cfg_wdata[ST_START]) f_start <= 1'b0;
         if (frame_end)                           f_end <= 1'b1;
         else if (stat_we && cfg_wdata[ST_END])   f_end <= 1'b0;
         if (frame_end && fetch_busy)             f_ovr <= 1'b1;
         else if (stat_we && cfg_wdata[ST_OVR])   f_ovr <= 1'b0;
         if (accept)                              run_r <= 1'b0;
         else if (frame_start && !fetch_busy)     run_r <= 1'b1;
      end
   end

   assign go       = accept && (pend_r || act_vld_r);
   assign go_base  = pend_r ? q_base_r : act_base_r;
   assign go_count = pend_r ? q_cnt_r  : act_cnt_r;
   assign q_base   = q_base_r;
   assign cnt_val  = cnt_r;
   assign status   = {f_ovr, f_end, f_start, pend_r};
   assign ien      = {ien_r, 1'b0};
   assign run      = run_r;
   assign irq_raw  = |(status[3:1] & ien_r);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |=> pend_r) else $error("pending not set"); // R1
   AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !ptr_we) |=> !pend_r) else $error("pending not cleared"); // R1
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (f_ovr && !(stat_we && cfg_wdata[ST_OVR])) |=> f_ovr) else $error("overrun flag lost"); // R8
   AST_RUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !run_r) else $error("run still high after frame end"); // R11
endmodule

// File: rtl/frame_list_loader.sv
`timescale 1ns/1ps
module frame_list_loader
   import flp_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CW      = 8,
   parameter int RAW     = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [2:0]     cfg_sel,
   input  logic [31:0]    cfg_wdata,
   input  logic [2:0]     cfg_rsel,
   output logic [31:0]    cfg_rdata,
   input  logic           frame_start,
   input  logic           frame_end,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic           mem_rvalid,
   input  logic [31:0]    mem_rdata,
   output logic           reg_we,
   output logic [RAW-1:0] reg_waddr,
   output logic [31:0]    reg_wdata,
   output logic           run,
   output logic           irq
);
   initial begin : elab_chk
      assert (AW >= 4 && AW <= 32) else $error("AW out of range");
      assert (CW >= 1 && CW + 3 <= AW) else $error("CW out of range");
      assert (RAW >= 1 && RAW <= 32) else $error("RAW out of range");
   end

   logic          go, busy;
   logic [AW-1:0] go_base, q_base, cur_base, shadow;
   logic [CW-1:0] go_count, cnt_val;
   logic [3:0]    status, ien;

   flp_regs #(.AW(AW), .CW(CW), .IRQ_REG(IRQ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start), .frame_end(frame_end),
      .fetch_busy(busy), .go(go), .go_base(go_base), .go_count(go_count),
      .q_base(q_base), .cnt_val(cnt_val), .status(status), .ien(ien),
      .run(run), .irq(irq)
   );

   flp_fetch #(.AW(AW), .CW(CW), .RAW(RAW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(go), .go_base(go_base), .go_count(go_count),
      .busy(busy), .cur_base(cur_base), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .reg_we(reg_we),
      .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
   );

   assign shadow = busy ? cur_base : q_base;

   always_comb begin
      case (cfg_rsel)
         SEL_PTR:    cfg_rdata = 32'(q_base);
         SEL_CNT:    cfg_rdata = 32'(cnt_val);
         SEL_STAT:   cfg_rdata = 32'(status);
         SEL_IEN:    cfg_rdata = 32'(ien);
         SEL_SHADOW: cfg_rdata = 32'(shadow);
         default:    cfg_rdata = '0;
      endcase
   end

   AST_RUN_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !run) else $error("run high during fetch"); // R11
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go) |=> !mem_req) else $error("read without fetch"); // R6
endmodule

// File: tb/tb_frame_list_loader.sv
`timescale 1ns/1ps
module tb_frame_list_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [2:0]  cfg_rsel = '0;
   logic [31:0] cfg_rdata;
   logic        frame_start = 1'b0, frame_end = 1'b0;
   logic        mem_req, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic        reg_we, run, irq;
   logic [7:0]  reg_waddr;
   logic [31:0] reg_wdata;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [31:0] q_addr[$];
   logic [39:0] q_wr[$];
   logic [31:0] raddr = '0;
   int dly = 0;

   always #10 clk = ~clk;

   frame_list_loader dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
      .frame_start(frame_start), .frame_end(frame_end), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .run(run), .irq(irq)
   );

   function automatic logic [31:0] word(input logic [31:0] a);
      return (a * 32'h0001_0003) ^ 32'hA5A5_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // memory model: response two edges after the request edge
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
         dly   <= 2;
         raddr <= mem_addr;
      end else if (dly != 0) begin
         dly <= dly - 1;
         if (dly == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= word(raddr);
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_req) begin
            if (q_addr.size() == 0) chk(0, "R2 unexpected read", 64'(mem_addr), 0);
            else begin
               logic [31:0] e;
               e = q_addr.pop_front();
               chk(mem_addr == e, "R2 read address", 64'(mem_addr), 64'(e));
            end
         end
         if (reg_we) begin
            if (q_wr.size() == 0) chk(0, "R3 unexpected write", 64'({reg_waddr, reg_wdata}), 0);
            else begin
               logic [39:0] e;
               e = q_wr.pop_front();
               chk({reg_waddr, reg_wdata} == e, "R3 register write", 64'({reg_waddr, reg_wdata}), 64'(e));
            end
         end
      end
   end

   task automatic expect_list(input logic [31:0] base, input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] a;
         a = base + 32'(8 * i);
         q_addr.push_back(a);
         q_addr.push_back(a + 4);
         q_wr.push_back({word(a)[7:0], word(a + 4)});
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [2:0] sel, output logic [31:0] d);
      cfg_rsel = sel;
      #1;
      d = cfg_rdata;
   endtask

   task automatic pulse_end();
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drained(input string req);
      chk(q_addr.size() == 0 && q_wr.size() == 0, req,
          64'(q_addr.size() + q_wr.size()), 0);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      wait_cyc(3);
      // R12 reset state
      cfg_read(3'd2, d); chk(d == 0, "R12 status", 64'(d), 0);
      cfg_read(3'd4, d); chk(d == 0, "R12 shadow", 64'(d), 0);
      chk({run, irq, mem_req, reg_we} == 0, "R12 outputs", 64'({run, irq, mem_req, reg_we}), 0);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 pointer write sets pending
      cfg_write(3'd1, 3);
      cfg_write(3'd0, 32'h1000);
      cfg_read(3'd2, d); chk(d[0] == 1'b1, "R1 pending set", 64'(d), 1);
      cfg_read(3'd4, d); chk(d == 32'h1000, "R7 shadow idle", 64'(d), 64'h1000);

      expect_list(32'h1000, 3);
      pulse_end();
      cfg_read(3'd2, d); chk(d[0] == 1'b0, "R1 pending cleared", 64'(d), 0);
      cfg_read(3'd4, d); chk(d == 32'h1000, "R7 shadow busy", 64'(d), 64'h1000);
      cfg_write(3'd1, 2);
      cfg_write(3'd0, 32'h2000);
      cfg_read(3'd4, d); chk(d == 32'h1000, "R7 shadow busy after new pointer", 64'(d), 64'h1000);
      wait_cyc(100);
      drained("R3 list applied");
      cfg_read(3'd4, d); chk(d == 32'h2000, "R7 shadow back to pointer", 64'(d), 64'h2000);
      cfg_read(3'd2, d); chk(d[2] == 1'b1, "R9 end flag", 64'(d), 64'h4);
      chk(run == 1'b0, "R11 run low after frame end", 64'(run), 0);
      pulse_start();
      chk(run == 1'b1, "R11 run high after start", 64'(run), 1);
      wait_cyc(1);
      cfg_read(3'd2, d); chk(d[1] == 1'b1, "R9 start flag", 64'(d), 64'h2);

      // R10 interrupt gating and R9 write-1-to-clear
      chk(irq == 1'b0, "R10 irq masked", 64'(irq), 0);
      cfg_write(3'd3, 32'h2);
      wait_cyc(2);
      chk(irq == 1'b1, "R10 irq start enabled", 64'(irq), 1);
      cfg_write(3'd2, 32'h2);
      wait_cyc(2);
      cfg_read(3'd2, d); chk(d[1] == 1'b0, "R9 start flag cleared", 64'(d), 0);
      chk(irq == 1'b0, "R10 irq dropped", 64'(irq), 0);
      cfg_write(3'd3, 32'h4);
      wait_cyc(2);
      chk(irq == 1'b1, "R10 irq end enabled", 64'(irq), 1);
      cfg_write(3'd2, 32'hE);
      wait_cyc(2);
      cfg_read(3'd2, d); chk(d == 32'h1, "R9 all cleared pending kept", 64'(d), 1);
      chk(irq == 1'b0, "R10 irq after clear", 64'(irq), 0);
      cfg_write(3'd3, 32'h0);

      // queued list, frame start during fetch ignored
      expect_list(32'h2000, 2);
      pulse_end();
      pulse_start();
      chk(run == 1'b0, "R11 start during fetch", 64'(run), 0);
      wait_cyc(80);
      drained("R1 queued list applied");
      pulse_start();
      chk(run == 1'b1, "R11 run after idle start", 64'(run), 1);

      // R4 reapply same list
      expect_list(32'h2000, 2);
      pulse_end();
      wait_cyc(80);
      drained("R4 list reapplied");

      // R5 one-deep queue
      cfg_write(3'd1, 1);
      cfg_write(3'd0, 32'h3000);
      cfg_write(3'd1, 4);
      cfg_write(3'd0, 32'h4000);
      expect_list(32'h4000, 4);
      pulse_end();
      wait_cyc(100);
      drained("R5 later pointer replaces earlier");

      // R8 overrun
      cfg_write(3'd2, 32'hE);
      expect_list(32'h4000, 4);
      pulse_end();
      wait_cyc(3);
      pulse_end();
      wait_cyc(100);
      drained("R8 overlapping frame end ignored");
      cfg_read(3'd2, d); chk(d[3] == 1'b1, "R8 overrun flag", 64'(d), 64'h8);

      // R6 zero count
      cfg_write(3'd1, 0);
      cfg_write(3'd0, 32'h5000);
      pulse_end();
      chk(run == 1'b0, "R11 run low zero list", 64'(run), 0);
      wait_cyc(20);
      cfg_read(3'd2, d); chk(d[0] == 1'b0, "R6 pending cleared zero list", 64'(d), 0);
      pulse_start();
      chk(run == 1'b1, "R11 run high zero list", 64'(run), 1);
      pulse_end();
      wait_cyc(20);
      drained("R6 zero count no traffic");
      cfg_read(3'd4, d); chk(d == 32'h5000, "R7 shadow zero list", 64'(d), 64'h5000);

      wait_cyc(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule